// File: doc/BRIEF.md
# DMA Address Translation Unit

This block sits between DMA-capable devices and the system bus. A device presents a 24-bit address; the block splits it into an 11-bit page number and a 13-bit byte offset, looks the page up in a table of 2048 descriptors, and returns a 32-bit bus address made of the descriptor's frame bits and the unchanged offset. With the address it returns two attribute flags from the descriptor (do-not-cache and whole-block-write) and a fault code.

Each descriptor is a 32-bit word. Bits 31..13 hold the frame address and bit 6 the do-not-cache flag. Bit 5 is the whole-block-write flag, bit 4 a modified flag and bit 3 an accessed flag. Bit 2 is the write-lock flag and bits 1..0 the kind code. Bits 12..7 are not stored. A host port reads and writes descriptors by page number. Devices whose address bus is narrower than 24 bits state their width on each request, and the block sets every address bit at or above that width to one before the lookup, so such a device lands in the top of the space.

Requests use a valid/ready handshake. A result appears one clock after acceptance and is held until the consumer takes it. After reset every descriptor reads as zero, so every page faults until the host programs it.

Top module: `dvma_xlate`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_vld` is 0, and every descriptor reads 0 on the host port. A lookup of an unprogrammed page returns `rsp_hit`=0 with `rsp_fault`=1 (invalid).
- R2: A host write to index i stores the word. A host read of i returns it on `hst_rdata` one clock after `hst_re`, with bits 12..7 read as zero.
- R3: For a kind code of 01 and no lock violation, the result has `rsp_hit`=1 and `rsp_fault`=0. `rsp_addr` is descriptor bits 31..13 joined with lookup address bits 12..0.
- R4: On a successful lookup, `rsp_ci` equals descriptor bit 6 and `rsp_bx` equals descriptor bit 5.
- R5: A kind code of 00 gives `rsp_hit`=0 and `rsp_fault`=1, whatever the frame bits hold.
- R6: A kind code with bit 1 set (10 or 11) gives `rsp_hit`=0 and `rsp_fault`=2.
- R7: A write request (`req_write`=1) to a page of kind 01 with descriptor bit 2 set gives `rsp_hit`=0 and `rsp_fault`=3. A read request to the same page translates normally.
- R8: When `req_width` is below 24, address bits 23..`req_width` are forced to one before both the page lookup and the offset. When it is 24 or more, the address is used as given.
- R9: A request accepted on a clock edge (`req_valid` and `req_ready` both 1) sets `rsp_vld` on that edge. While `rsp_vld`=1 and `rsp_ready`=0 the result is held unchanged and `req_ready` is 0.
- R10: When a host write and a request hit the same index on the same edge, the request sees the old descriptor. The next request sees the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_re | input | 1 | Host read strobe |
| hst_we | input | 1 | Host write strobe |
| hst_idx | input | 11 | Descriptor index (page number) |
| hst_wdata | input | 32 | Descriptor word to write |
| hst_rdata | output | 32 | Descriptor word read, valid one clock after `hst_re` |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | 24 | Device address |
| req_write | input | 1 | 1 for a device write, 0 for a read |
| req_width | input | 5 | Device address bus width in bits |
| rsp_vld | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 32 | Translated bus address (meaningless on a fault) |
| rsp_hit | output | 1 | 1 when the translation succeeded |
| rsp_fault | output | 2 | 0 none, 1 invalid page, 2 malformed, 3 write-lock |
| rsp_ci | output | 1 | Do-not-cache flag of the page |
| rsp_bx | output | 1 | Whole-block-write flag of the page |

## Verification
A host write and a device lookup can fall on the same clock edge and the same descriptor. In that case the lookup must use the word as it stood before the write. The bench sets up this case by raising `hst_we` and `req_valid` together on one index. It holds the scoreboard's expectation for that request at the old descriptor and sets the following request's expectation to the new one. The same collision between the host read port and a device lookup is exercised while the consumer applies backpressure, so a held result must not be disturbed by table traffic.

// File: rtl/dvma_pkg.sv
package dvma_pkg;
  // Descriptor field positions; a neighbour decodes these, so they are fixed.
  localparam int ATTR_W = 7;
  localparam int CI_BIT = 6;
  localparam int BX_BIT = 5;
  localparam int WP_BIT = 2;

  typedef enum logic [1:0] {
    FLT_NONE      = 2'd0,
    FLT_INVALID   = 2'd1,
    FLT_MALFORMED = 2'd2,
    FLT_PROTECT   = 2'd3
  } fault_e;
endpackage

// File: rtl/dvma_desc_table.sv
module dvma_desc_table #(
  parameter int NENT     = 2048,
  parameter int WORD_W   = 32,
  parameter int PG_SHIFT = 13,
  localparam int IDX_W   = $clog2(NENT),
  localparam int PFN_W   = WORD_W - PG_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              hr_en,
  input  logic [IDX_W-1:0]  hr_idx,
  output logic [WORD_W-1:0] hr_word,
  input  logic [IDX_W-1:0]  dr_idx,
  output logic [PFN_W-1:0]  dr_pfn,
  output logic              dr_ci,
  output logic              dr_bx,
  output logic              dr_wp,
  output logic [1:0]        dr_kind
);
  import dvma_pkg::*;

  // Bits between the attribute field and the frame field are never kept.
  localparam logic [WORD_W-1:0] KEEP_MASK =
    ~((WORD_W'(1) << PG_SHIFT) - (WORD_W'(1) << ATTR_W));

  logic [WORD_W-1:0] mem [NENT];
  logic [NENT-1:0]   filled;
  logic              dr_filled;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_word & KEEP_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     filled <= '0;
    else if (wr_en) filled[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     hr_word <= '0;
    else if (hr_en) hr_word <= filled[hr_idx] ? mem[hr_idx] : '0;
  end

  assign dr_filled = filled[dr_idx];

  always_comb begin
    dr_pfn  = dr_filled ? mem[dr_idx][WORD_W-1:PG_SHIFT] : '0;
    dr_ci   = dr_filled & mem[dr_idx][CI_BIT];
    dr_bx   = dr_filled & mem[dr_idx][BX_BIT];
    dr_wp   = dr_filled & mem[dr_idx][WP_BIT];
    dr_kind = dr_filled ? mem[dr_idx][1:0] : 2'b00;
  end

  AST_UNWRITTEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_en && !filled[hr_idx]) |=> (hr_word == '0)); // R1
endmodule

// File: rtl/dvma_desc_check.sv
module dvma_desc_check (
  input  logic       is_write,
  input  logic       wp,
  input  logic [1:0] kind,
  output logic [1:0] fault,
  output logic       hit
);
  import dvma_pkg::*;

  fault_e f;

  always_comb begin
    if (kind[1])               f = FLT_MALFORMED;
    else if (!kind[0])         f = FLT_INVALID;
    else if (is_write && wp)   f = FLT_PROTECT;
    else                       f = FLT_NONE;
  end

  assign fault = f;
  assign hit   = (f == FLT_NONE);
endmodule

// File: rtl/dvma_rsp_stage.sv
module dvma_rsp_stage #(
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PA_W-1:0] in_addr,
  input  logic            in_hit,
  input  logic [1:0]      in_fault,
  input  logic            in_ci,
  input  logic            in_bx,
  input  logic            out_ready,
  output logic            out_vld,
  output logic [PA_W-1:0] out_addr,
  output logic            out_hit,
  output logic [1:0]      out_fault,
  output logic            out_ci,
  output logic            out_bx
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld   <= 1'b0;
      out_addr  <= '0;
      out_hit   <= 1'b0;
      out_fault <= 2'd0;
      out_ci    <= 1'b0;
      out_bx    <= 1'b0;
    end else if (load) begin
      out_vld   <= 1'b1;
      out_addr  <= in_addr;
      out_hit   <= in_hit;
      out_fault <= in_fault;
      out_ci    <= in_ci;
      out_bx    <= in_bx;
    end else if (out_ready) begin
      out_vld   <= 1'b0;
    end
  end

  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_ready) |=> (out_vld && $stable(out_addr) && $stable(out_fault)
                                  && $stable(out_hit))); // R9
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate #(
  parameter int VA_W     = 24,
  parameter int PA_W     = 32,
  parameter int PG_SHIFT = 13,
  localparam int NENT    = 1 << (VA_W - PG_SHIFT),
  localparam int IDX_W   = VA_W - PG_SHIFT,
  localparam int WID_W   = $clog2(VA_W + 1),
  localparam int PFN_W   = PA_W - PG_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hst_re,
  input  logic             hst_we,
  input  logic [IDX_W-1:0] hst_idx,
  input  logic [PA_W-1:0]  hst_wdata,
  output logic [PA_W-1:0]  hst_rdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_addr,
  input  logic             req_write,
  input  logic [WID_W-1:0] req_width,
  output logic             rsp_vld,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_addr,
  output logic             rsp_hit,
  output logic [1:0]       rsp_fault,
  output logic             rsp_ci,
  output logic             rsp_bx
);
  import dvma_pkg::*;

  // Narrow devices: every bit at or above their width reads as one.
  function automatic logic [VA_W-1:0] pin_top(input logic [VA_W-1:0] a,
                                              input logic [WID_W-1:0] n);
    for (int i = 0; i < VA_W; i++) pin_top[i] = (i >= int'(n)) ? 1'b1 : a[i];
  endfunction

  function automatic logic [PA_W-1:0] join_addr(input logic [PFN_W-1:0] pfn,
                                                input logic [VA_W-1:0] la);
    return {pfn, la[PG_SHIFT-1:0]};
  endfunction

  logic [VA_W-1:0]  lookup_addr;
  logic [IDX_W-1:0] lookup_page;
  logic             accept;
  logic [PFN_W-1:0] tbl_pfn;
  logic             tbl_ci, tbl_bx, tbl_wp;
  logic [1:0]       tbl_kind;
  logic [1:0]       chk_fault;
  logic             chk_hit;
  logic [PA_W-1:0]  xl_addr;

  assign lookup_addr = pin_top(req_addr, req_width);
  assign lookup_page = lookup_addr[VA_W-1:PG_SHIFT];
  assign req_ready   = !rsp_vld || rsp_ready;
  assign accept      = req_valid && req_ready;
  assign xl_addr     = join_addr(tbl_pfn, lookup_addr);

  dvma_desc_table #(.NENT(NENT), .WORD_W(PA_W), .PG_SHIFT(PG_SHIFT)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (hst_we),
    .wr_idx  (hst_idx),
    .wr_word (hst_wdata),
    .hr_en   (hst_re),
    .hr_idx  (hst_idx),
    .hr_word (hst_rdata),
    .dr_idx  (lookup_page),
    .dr_pfn  (tbl_pfn),
    .dr_ci   (tbl_ci),
    .dr_bx   (tbl_bx),
    .dr_wp   (tbl_wp),
    .dr_kind (tbl_kind)
  );

  dvma_desc_check u_check (
    .is_write (req_write),
    .wp       (tbl_wp),
    .kind     (tbl_kind),
    .fault    (chk_fault),
    .hit      (chk_hit)
  );

  dvma_rsp_stage #(.PA_W(PA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .in_addr   (xl_addr),
    .in_hit    (chk_hit),
    .in_fault  (chk_fault),
    .in_ci     (tbl_ci),
    .in_bx     (tbl_bx),
    .out_ready (rsp_ready),
    .out_vld   (rsp_vld),
    .out_addr  (rsp_addr),
    .out_hit   (rsp_hit),
    .out_fault (rsp_fault),
    .out_ci    (rsp_ci),
    .out_bx    (rsp_bx)
  );

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_vld); // R9
  AST_MALFORMED_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && tbl_kind[1]) |=> (!rsp_hit && rsp_fault == FLT_MALFORMED)); // R6
  AST_LOCK_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && tbl_wp && tbl_kind == 2'b01)
      |=> (!rsp_hit && rsp_fault == FLT_PROTECT)); // R7
  AST_NARROW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && int'(req_width) < VA_W) |-> lookup_addr[VA_W-1]); // R8
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && chk_hit)
      |=> (rsp_addr[PG_SHIFT-1:0] == $past(lookup_addr[PG_SHIFT-1:0]))); // R3
endmodule

// File: tb/dvma_xlate_test.sv
`timescale 1ns/1ps
module dvma_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_re = 1'b0, hst_we = 1'b0;
  logic [10:0] hst_idx = '0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        req_valid = 1'b0, req_ready;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [4:0]  req_width = 5'd24;
  logic        rsp_vld, rsp_ready = 1'b1;
  logic [31:0] rsp_addr;
  logic        rsp_hit, rsp_ci, rsp_bx;
  logic [1:0]  rsp_fault;

  int n_cmp = 0, n_bad = 0;
  int rdy_mode = 0;   // 0 always ready, 1 alternate, 2 stalled
  int cyc = 0;
  logic [31:0] model [2048];

  typedef struct {
    string       tag;
    logic        hit;
    logic [1:0]  fault;
    logic [31:0] addr;
    logic        ci, bx;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  dvma_xlate uut (
    .clk(clk), .rst_n(rst_n), .hst_re(hst_re), .hst_we(hst_we), .hst_idx(hst_idx),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .req_width(req_width), .rsp_vld(rsp_vld), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_ci(rsp_ci), .rsp_bx(rsp_bx)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected result computed from the requirements.
  function automatic exp_t predict(input string tag, input logic [23:0] a,
                                   input logic wr, input logic [4:0] w);
    exp_t e;
    logic [31:0] ones, la, d;
    ones = (w >= 5'd24) ? 32'h0 : ((32'h00FF_FFFF << w) & 32'h00FF_FFFF);
    la = {8'h0, a} | ones;
    d = model[la[23:13]];
    e.tag = tag;
    if (d[1])             e.fault = 2'd2;
    else if (d[0] == 1'b0) e.fault = 2'd1;
    else if (wr && d[2])  e.fault = 2'd3;
    else                  e.fault = 2'd0;
    e.hit  = (e.fault == 2'd0);
    e.addr = {d[31:13], la[12:0]};
    e.ci   = d[6];
    e.bx   = d[5];
    return e;
  endfunction

  always begin
    @(posedge clk); #1;
    cyc++;
    case (rdy_mode)
      0: rsp_ready = 1'b1;
      1: rsp_ready = cyc[0];
      default: rsp_ready = 1'b0;
    endcase
  end

  // Monitor: a result present with ready high is consumed at the next edge.
  always @(negedge clk) begin
    if (rst_n && rsp_vld && rsp_ready) begin
      if (sb.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R9 unexpected result actual=%h expected=none", rsp_addr);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " hit"}, {31'h0, rsp_hit}, {31'h0, e.hit});
        check({e.tag, " fault"}, {30'h0, rsp_fault}, {30'h0, e.fault});
        if (e.hit) begin
          check({e.tag, " addr"}, rsp_addr, e.addr);
          check({e.tag, " ci"}, {31'h0, rsp_ci}, {31'h0, e.ci});
          check({e.tag, " bx"}, {31'h0, rsp_bx}, {31'h0, e.bx});
        end
      end
    end
  end

  task automatic host_write(input logic [10:0] i, input logic [31:0] w);
    @(negedge clk);
    hst_we = 1'b1; hst_idx = i; hst_wdata = w;
    @(negedge clk);
    hst_we = 1'b0;
    model[i] = w & ~32'h0000_1F80;
  endtask

  task automatic host_read(input string tag, input logic [10:0] i);
    @(negedge clk);
    hst_re = 1'b1; hst_idx = i;
    @(negedge clk);
    hst_re = 1'b0;
    check(tag, hst_rdata, model[i]);
  endtask

  task automatic send(input string tag, input logic [23:0] a, input logic wr,
                      input logic [4:0] w);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_width = w;
    while (!req_ready) @(negedge clk);
    sb.push_back(predict(tag, a, wr, w));
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 valid one clock after accept", {31'h0, rsp_vld}, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) model[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 req_ready after reset", {31'h0, req_ready}, 32'h1);
    check("R1 rsp_vld after reset", {31'h0, rsp_vld}, 32'h0);
    host_read("R1 entry 0 reads zero", 11'd0);
    host_read("R1 entry 2047 reads zero", 11'd2047);
    send("R1 unprogrammed page", 24'h123456, 1'b0, 5'd24);

    // R2: write/read with unused bits discarded
    host_write(11'd5, 32'hABCD_E041);
    host_write(11'd6, 32'h1234_5FFD);
    host_read("R2 readback entry 5", 11'd5);
    host_read("R2 unused bits cleared", 11'd6);
    check("R2 explicit mask", model[6], 32'h1234_407D);

    // R3, R4: valid pages
    send("R3 R4 page 5 read", {11'd5, 13'h0ABC}, 1'b0, 5'd24);
    send("R3 page 5 write", {11'd5, 13'h1FFF}, 1'b1, 5'd24);
    // R7: lock on page 6
    send("R7 write to locked page", {11'd6, 13'h0010}, 1'b1, 5'd24);
    send("R7 R4 read of locked page", {11'd6, 13'h0010}, 1'b0, 5'd24);

    // R5, R6
    host_write(11'd7, 32'h5555_E042);
    host_write(11'd8, 32'h6666_0003);
    host_write(11'd9, 32'h7777_E064);
    send("R6 kind 10", {11'd7, 13'h0001}, 1'b0, 5'd24);
    send("R6 kind 11", {11'd8, 13'h0002}, 1'b1, 5'd24);
    send("R5 kind 00 nonzero frame", {11'd9, 13'h0003}, 1'b0, 5'd24);

    // R8: narrow devices
    host_write(11'h7F8, 32'h8000_0001);
    host_write(11'h789, 32'h4000_2021);
    host_write(11'h7FF, 32'hC000_0041);
    send("R8 width 16", 24'h000100, 1'b0, 5'd16);
    check("R8 width 16 model", predict("x", 24'h000100, 1'b0, 5'd16).addr, 32'h8000_0100);
    send("R8 width 20", 24'h012345, 1'b1, 5'd20);
    send("R8 width 11", 24'h000000, 1'b0, 5'd11);
    send("R8 width 31 unchanged", {11'd5, 13'h0042}, 1'b0, 5'd31);

    // R10: same-edge host write and lookup
    host_write(11'd10, 32'h1111_E001);
    @(negedge clk);
    req_valid = 1'b1; req_addr = {11'd10, 13'h0044}; req_write = 1'b0; req_width = 5'd24;
    hst_we = 1'b1; hst_idx = 11'd10; hst_wdata = 32'h2222_0041;
    sb.push_back(predict("R10 old descriptor seen", req_addr, 1'b0, 5'd24));
    @(negedge clk);
    req_valid = 1'b0; hst_we = 1'b0;
    model[10] = 32'h2222_0041;
    send("R10 new descriptor next", {11'd10, 13'h0044}, 1'b0, 5'd24);

    // R9: backpressure and held result, with host read colliding
    rdy_mode = 2;
    repeat (2) @(negedge clk);
    send("R9 stalled", {11'd5, 13'h0100}, 1'b0, 5'd24);
    repeat (3) @(negedge clk);
    check("R9 held vld", {31'h0, rsp_vld}, 32'h1);
    check("R9 ready low when held", {31'h0, req_ready}, 32'h0);
    check("R9 held addr", rsp_addr, 32'hABCD_E100);
    host_read("R2 read during stall", 11'd7);
    check("R9 held addr after host read", rsp_addr, 32'hABCD_E100);
    rdy_mode = 1;
    for (int k = 0; k < 8; k++)
      send("R9 burst alternate ready", {11'(k % 12), 13'(k * 37)}, k[0], 5'd24);
    rdy_mode = 0;

    for (int k = 0; k < 200 && (sb.size() != 0 || rsp_vld); k++) @(negedge clk);
    check("R9 scoreboard drained", sb.size(), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule